// File: doc/BRIEF.md
# Packed Double-to-Int32 Truncating Converter

This block turns a vector of IEEE-754 binary64 values into signed 32-bit integers. It always rounds toward zero. It can handle two, four or eight lanes in one operation. The 32-bit results are packed from bit 0 of a wide destination word. A per-lane write mask picks which lanes take their result. Each unselected lane either keeps the old destination contents (merge) or is forced to zero (zeroing). A broadcast option feeds one 64-bit value to every lane. A legacy option changes how the destination bits above the results are treated.

Operations arrive on a valid/ready stream, together with the old destination word. Each accepted operation produces one result beat on an output valid/ready stream. That beat appears on the clock edge after acceptance. The block holds a single result. The input is ready whenever that slot is empty or is being drained in the same cycle. So back-pressure on the output passes straight to the input, and no operation is lost or duplicated.

Two sticky status flags gather exceptional conditions from every lane that was written. One flag reports invalid conversions and the other reports inexact ones. Only a reset clears them.

Top module: `pk_f64_to_i32_rz`

## Requirements
- R1: Each active lane converts its binary64 input to a signed 32-bit integer by rounding toward zero. Lane i's result sits at destination bits [32*i+31 : 32*i], and lane i's source is at src_vec bits [64*i+63 : 64*i].
- R2: A lane input that is NaN (exponent field all ones, non-zero fraction) or ±infinity (exponent field all ones, zero fraction) yields 32'h80000000 and counts as invalid.
- R3: Inputs of 2^31 or more yield 32'h80000000 and are invalid. Inputs of -2^31-1 or less are also invalid. Inputs greater than -2^31-1 and at most -2^31 give -2147483648 without invalid. Both 2147483647.0 and -2147483648.0 convert exactly.
- R4: lane_sel picks the lane count: 0 means 2 lanes, 1 means 4 lanes, and 2 or 3 mean 8 lanes.
- R5: With bcast_en=1, every active lane converts src_vec[63:0] and the other source bits are ignored.
- R6: When legacy handling is off, an active lane whose lane_mask bit (bit i for lane i) is 0 takes the old_dst bits of that lane if zero_mode=0, or zero if zero_mode=1.
- R7: When legacy handling is off, every destination bit at or above 32 × lane count is zero. For 2 lanes, this means bits 511:64 are zero.
- R8: With legacy_mode=1 and lane_sel=0, both lanes are written whatever lane_mask and zero_mode say. Bits 127:64 are zero and bits 511:128 keep old_dst. With any other lane_sel, legacy_mode has no effect.
- R9: flag_invalid and flag_inexact are sticky and are cleared only by reset. They are updated with each result from the lanes that were written. Inexact means non-zero fraction bits were dropped in a lane that was not invalid; this includes subnormal inputs, which give 0. Unwritten lanes add nothing.
- R10: An operation is accepted when in_valid and in_ready are both 1. in_ready equals !out_valid || out_ready. The result appears with out_valid=1 on the next clock edge. dst_vec and the flags stay stable while out_valid=1 and out_ready=0.
- R11: During reset, out_valid, dst_vec, flag_invalid and flag_inexact are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| src_vec | input | 512 | Eight binary64 source lanes |
| bcast_en | input | 1 | Use src_vec[63:0] for every lane |
| lane_sel | input | 2 | Lane count select (0:2, 1:4, 2/3:8) |
| lane_mask | input | 8 | Per-lane write enable |
| zero_mode | input | 1 | 1: unwritten lanes become zero; 0: they merge old_dst |
| legacy_mode | input | 1 | Legacy upper-bit handling for 2 lanes |
| old_dst | input | 512 | Previous destination contents |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| dst_vec | output | 512 | New destination contents |
| flag_invalid | output | 1 | Sticky invalid-conversion flag |
| flag_inexact | output | 1 | Sticky inexact flag |

## Verification
The destination word and both flags are due on the first rising edge after the cycle in which in_valid and in_ready are both high. They then stay put for as long as out_ready is held low. The bench drives inputs on falling edges and advances its reference model by one clock at each falling edge, using the same out_ready and in_valid it has just applied. At the next falling edge it compares out_valid, in_ready, dst_vec and both flags against that model. A result that is one cycle late or early, or that changes during a stall, therefore shows up as a mismatch in the cycle where it happens.

// File: rtl/pktc_pkg.sv
package pktc_pkg;
  localparam int unsigned FP_EXP_W = 11;
  localparam int unsigned FP_MAN_W = 52;
  localparam int unsigned FP_W     = FP_EXP_W + FP_MAN_W + 1;
  localparam int unsigned RES_W    = 32;

  typedef struct packed {
    logic [RES_W-1:0] val;
    logic             inv;
    logic             inx;
  } cvt_res_t;

  // value returned for every unrepresentable input
  localparam logic [RES_W-1:0] RES_INDEF = {1'b1, {(RES_W-1){1'b0}}};
endpackage

// File: rtl/pktc_lane_cvt.sv
module pktc_lane_cvt
  import pktc_pkg::*;
#(
  parameter int unsigned EXP_W = FP_EXP_W,
  parameter int unsigned MAN_W = FP_MAN_W,
  parameter int unsigned INT_W = RES_W
) (
  input  logic [EXP_W+MAN_W:0] fp_i,
  output logic [INT_W-1:0]     val_o,
  output logic                 inv_o,
  output logic                 inx_o
);
  localparam int unsigned SIG_W = MAN_W + 1;
  localparam int unsigned BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int unsigned SH_W  = $clog2(SIG_W + 1);

  logic                 sgn;
  logic [EXP_W-1:0]     expo;
  logic [MAN_W-1:0]     man;
  logic [SIG_W-1:0]     sig;
  logic [EXP_W-1:0]     unb;
  logic [SH_W-1:0]      shamt;
  logic [SIG_W-1:0]     mag;
  logic [SIG_W-1:0]     lost_mask;
  logic [INT_W-1:0]     mag_i;

  assign sgn  = fp_i[EXP_W+MAN_W];
  assign expo = fp_i[EXP_W+MAN_W-1:MAN_W];
  assign man  = fp_i[MAN_W-1:0];
  assign sig  = {1'b1, man};
  assign unb  = expo - EXP_W'(BIAS);

  always_comb begin
    val_o     = '0;
    inv_o     = 1'b0;
    inx_o     = 1'b0;
    shamt     = '0;
    mag       = '0;
    lost_mask = '0;
    mag_i     = '0;
    if (&expo) begin
      // NaN or infinity
      inv_o = 1'b1;
    end else if (expo < EXP_W'(BIAS)) begin
      // magnitude below one, including subnormals and zero
      inx_o = |{expo, man};
    end else if (unb > EXP_W'(INT_W - 1)) begin
      inv_o = 1'b1;
    end else begin
      shamt     = SH_W'(MAN_W) - SH_W'(unb);
      mag       = sig >> shamt;
      lost_mask = ~({SIG_W{1'b1}} << shamt);
      inx_o     = |(sig & lost_mask);
      mag_i     = mag[INT_W-1:0];
      if (unb == EXP_W'(INT_W - 1)) begin
        // only the most negative integer fits at this exponent
        if (sgn && (mag_i[INT_W-2:0] == '0)) begin
          val_o = mag_i;
        end else begin
          inv_o = 1'b1;
          inx_o = 1'b0;
        end
      end else begin
        val_o = sgn ? (~mag_i + INT_W'(1)) : mag_i;
      end
    end
    if (inv_o) val_o = {1'b1, {(INT_W-1){1'b0}}};
  end
endmodule

// File: rtl/pktc_src_fanout.sv
module pktc_src_fanout #(
  parameter int unsigned LANES     = 8,
  parameter int unsigned LANE_W    = 64,
  parameter int unsigned SEL_W     = 2,
  parameter int unsigned MIN_LANES = 2
) (
  input  logic [LANES*LANE_W-1:0]        src_i,
  input  logic                           bcast_i,
  input  logic [SEL_W-1:0]               sel_i,
  output logic [LANES-1:0][LANE_W-1:0]   lane_o,
  output logic [LANES-1:0]               act_o
);
  logic [31:0] cnt;

  always_comb begin
    cnt = 32'(MIN_LANES) << sel_i;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      lane_o[i] = bcast_i ? src_i[LANE_W-1:0] : src_i[LANE_W*i +: LANE_W];
      act_o[i]  = (32'(i) < cnt);
    end
  end
endmodule

// File: rtl/pktc_pack.sv
module pktc_pack
  import pktc_pkg::*;
#(
  parameter int unsigned LANES     = 8,
  parameter int unsigned LANE_W    = 64,
  parameter int unsigned INT_W     = RES_W,
  parameter int unsigned LEG_LANES = 2
) (
  input  cvt_res_t [LANES-1:0]      res_i,
  input  logic [LANES-1:0]          act_i,
  input  logic [LANES-1:0]          mask_i,
  input  logic                      zero_i,
  input  logic                      legacy_i,
  input  logic [LANES*LANE_W-1:0]   old_i,
  output logic [LANES*LANE_W-1:0]   dst_o,
  output logic                      inv_o,
  output logic                      inx_o
);
  localparam int unsigned VEC_W    = LANES * LANE_W;
  localparam int unsigned PACK_W   = LANES * INT_W;
  localparam int unsigned LEG_KEEP = LEG_LANES * LANE_W;

  logic [LANES-1:0] wr_en;
  logic [LANES-1:0] inv_v;
  logic [LANES-1:0] inx_v;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam bit ABOVE_LEG = (INT_W * i) >= LEG_KEEP;
    always_comb begin
      wr_en[i] = act_i[i] && (legacy_i || mask_i[i]);
      inv_v[i] = wr_en[i] && res_i[i].inv;
      inx_v[i] = wr_en[i] && res_i[i].inx;
      if (wr_en[i]) begin
        dst_o[INT_W*i +: INT_W] = res_i[i].val;
      end else if (act_i[i] && !legacy_i && !zero_i) begin
        dst_o[INT_W*i +: INT_W] = old_i[INT_W*i +: INT_W];
      end else if (legacy_i && ABOVE_LEG) begin
        dst_o[INT_W*i +: INT_W] = old_i[INT_W*i +: INT_W];
      end else begin
        dst_o[INT_W*i +: INT_W] = '0;
      end
    end
  end

  always_comb begin
    dst_o[VEC_W-1:PACK_W] = legacy_i ? old_i[VEC_W-1:PACK_W] : '0;
    inv_o = |inv_v;
    inx_o = |inx_v;
  end
endmodule

// File: rtl/pk_f64_to_i32_rz.sv
module pk_f64_to_i32_rz
  import pktc_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = FP_W,
  parameter int unsigned INT_W  = RES_W,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*LANE_W-1:0]   src_vec,
  input  logic                      bcast_en,
  input  logic [SEL_W-1:0]          lane_sel,
  input  logic [LANES-1:0]          lane_mask,
  input  logic                      zero_mode,
  input  logic                      legacy_mode,
  input  logic [LANES*LANE_W-1:0]   old_dst,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*LANE_W-1:0]   dst_vec,
  output logic                      flag_invalid,
  output logic                      flag_inexact
);
  localparam int unsigned VEC_W = LANES * LANE_W;

  logic [LANES-1:0][LANE_W-1:0] lane_src;
  logic [LANES-1:0]             lane_act;
  cvt_res_t [LANES-1:0]         lane_res;
  logic [VEC_W-1:0]             dst_d;
  logic                         inv_d;
  logic                         inx_d;
  logic                         legacy_eff;
  logic                         accept;

  assign legacy_eff = legacy_mode && (lane_sel == '0);
  assign in_ready   = !out_valid || out_ready;
  assign accept     = in_valid && in_ready;

  pktc_src_fanout #(
    .LANES (LANES),
    .LANE_W(LANE_W),
    .SEL_W (SEL_W)
  ) u_fanout (
    .src_i  (src_vec),
    .bcast_i(bcast_en),
    .sel_i  (lane_sel),
    .lane_o (lane_src),
    .act_o  (lane_act)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_cvt
    pktc_lane_cvt #(
      .EXP_W(FP_EXP_W),
      .MAN_W(LANE_W - FP_EXP_W - 1),
      .INT_W(INT_W)
    ) u_cvt (
      .fp_i (lane_src[i]),
      .val_o(lane_res[i].val),
      .inv_o(lane_res[i].inv),
      .inx_o(lane_res[i].inx)
    );
  end

  pktc_pack #(
    .LANES (LANES),
    .LANE_W(LANE_W),
    .INT_W (INT_W)
  ) u_pack (
    .res_i   (lane_res),
    .act_i   (lane_act),
    .mask_i  (lane_mask),
    .zero_i  (zero_mode),
    .legacy_i(legacy_eff),
    .old_i   (old_dst),
    .dst_o   (dst_d),
    .inv_o   (inv_d),
    .inx_o   (inx_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      dst_vec      <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
    end else begin
      if (accept) begin
        out_valid    <= 1'b1;
        dst_vec      <= dst_d;
        flag_invalid <= flag_invalid | inv_d;
        flag_inexact <= flag_inexact | inx_d;
      end else if (out_ready) begin
        out_valid    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pktc_chk.sv
module pktc_chk #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned LANE_W = 64,
  parameter int unsigned INT_W  = 32,
  parameter int unsigned SEL_W  = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [SEL_W-1:0]        lane_sel,
  input logic                    legacy_mode,
  input logic [LANES*LANE_W-1:0] old_dst,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*LANE_W-1:0] dst_vec,
  input logic                    flag_invalid,
  input logic                    flag_inexact
);
  localparam int unsigned VEC_W  = LANES * LANE_W;
  localparam int unsigned PACK_W = LANES * INT_W;
  localparam int unsigned TWO_W  = 2 * INT_W;
  localparam int unsigned KEEP_W = 2 * LANE_W;

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(dst_vec)
      && $stable(flag_invalid) && $stable(flag_inexact));

  // R10
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9
  inv_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_invalid |=> flag_invalid);

  // R9
  inx_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_inexact |=> flag_inexact);

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !legacy_mode |=> dst_vec[VEC_W-1:PACK_W] == '0);

  // R7
  two_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !legacy_mode && lane_sel == '0
      |=> dst_vec[VEC_W-1:TWO_W] == '0);

  // R8
  legacy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && legacy_mode && lane_sel == '0
      |=> dst_vec[VEC_W-1:KEEP_W] == $past(old_dst[VEC_W-1:KEEP_W])
        && dst_vec[KEEP_W-1:TWO_W] == '0);
endmodule

bind pk_f64_to_i32_rz pktc_chk #(
  .LANES (LANES),
  .LANE_W(LANE_W),
  .INT_W (INT_W),
  .SEL_W (SEL_W)
) u_pktc_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .lane_sel    (lane_sel),
  .legacy_mode (legacy_mode),
  .old_dst     (old_dst),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .dst_vec     (dst_vec),
  .flag_invalid(flag_invalid),
  .flag_inexact(flag_inexact)
);

// File: tb/test_pk_f64_to_i32_rz.sv
`timescale 1ns/1ps
module test_pk_f64_to_i32_rz;
  typedef struct {
    logic [511:0] src;
    bit           bc;
    logic [1:0]   sel;
    logic [7:0]   mask;
    bit           zm;
    logic [511:0] old;
    bit           leg;
    string        tag;
  } op_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [511:0] src_vec = '0;
  logic bcast_en = 1'b0;
  logic [1:0] lane_sel = '0;
  logic [7:0] lane_mask = '0;
  logic zero_mode = 1'b0;
  logic legacy_mode = 1'b0;
  logic [511:0] old_dst = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [511:0] dst_vec;
  logic flag_invalid;
  logic flag_inexact;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wd = 0;
  bit run = 1'b0;
  op_t q[$];

  bit           exp_valid = 1'b0;
  logic [511:0] exp_dst = '0;
  bit           exp_inv = 1'b0;
  bit           exp_inx = 1'b0;
  string        exp_tag = "R11";

  always #2 clk = ~clk;

  pk_f64_to_i32_rz i_pk_f64_to_i32_rz (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .src_vec(src_vec), .bcast_en(bcast_en), .lane_sel(lane_sel),
    .lane_mask(lane_mask), .zero_mode(zero_mode), .legacy_mode(legacy_mode),
    .old_dst(old_dst), .out_valid(out_valid), .out_ready(out_ready),
    .dst_vec(dst_vec), .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void ref_cvt(input logic [63:0] x, output logic [31:0] v,
                                  output bit inv, output bit inx);
    real r;
    int iv;
    inv = 0; inx = 0; v = 32'h8000_0000;
    if (x[62:52] == 11'h7FF) begin
      inv = 1;
      return;
    end
    r = $bitstoreal(x);
    if (r >= 2147483648.0 || r <= -2147483649.0) begin
      inv = 1;
      return;
    end
    iv = $rtoi(r);
    v = iv;
    inx = ($itor(iv) != r);
  endfunction

  function automatic void ref_op(input op_t o, output logic [511:0] d,
                                 output bit inv, output bit inx);
    int n;
    bit leg;
    logic [31:0] v;
    bit li, lx;
    n = (o.sel == 0) ? 2 : (o.sel == 1) ? 4 : 8;
    leg = o.leg && (o.sel == 0);
    d = '0; inv = 0; inx = 0;
    for (int i = 0; i < n; i++) begin
      if (leg || o.mask[i]) begin
        ref_cvt(o.bc ? o.src[63:0] : o.src[64*i +: 64], v, li, lx);
        d[32*i +: 32] = v;
        inv |= li;
        inx |= lx;
      end else if (!o.zm) begin
        d[32*i +: 32] = o.old[32*i +: 32];
      end
    end
    if (leg) d[511:128] = o.old[511:128];
  endfunction

  function automatic logic [511:0] old_pat();
    logic [511:0] p;
    for (int i = 0; i < 16; i++) p[32*i +: 32] = 32'hC0DE_0000 | 32'(i);
    return p;
  endfunction

  function automatic op_t mk(input string tag, input logic [1:0] sel,
                             input logic [7:0] mask, input bit zm,
                             input bit leg, input bit bc);
    op_t o;
    o.tag = tag; o.sel = sel; o.mask = mask; o.zm = zm; o.leg = leg; o.bc = bc;
    o.old = old_pat();
    for (int i = 0; i < 8; i++) o.src[64*i +: 64] = $realtobits(real'(i * 3 + 1));
    return o;
  endfunction

  // per-clock reference model and comparison
  always @(negedge clk) begin
    if (run) begin
      logic [511:0] d;
      bit vi, vx, acc;
      chk(out_valid === exp_valid, "R10", "out_valid", 512'(out_valid), 512'(exp_valid));
      chk(in_ready === (!exp_valid || out_ready), "R10", "in_ready",
          512'(in_ready), 512'(!exp_valid || out_ready));
      chk(flag_invalid === exp_inv, {exp_tag, " R9"}, "flag_invalid",
          512'(flag_invalid), 512'(exp_inv));
      chk(flag_inexact === exp_inx, {exp_tag, " R9"}, "flag_inexact",
          512'(flag_inexact), 512'(exp_inx));
      if (exp_valid) chk(dst_vec === exp_dst, exp_tag, "dst_vec", dst_vec, exp_dst);
      out_ready = ((cyc % 5) != 3);
      in_valid = (q.size() > 0) && ((cyc % 7) != 6);
      if (in_valid) begin
        src_vec = q[0].src; bcast_en = q[0].bc; lane_sel = q[0].sel;
        lane_mask = q[0].mask; zero_mode = q[0].zm; legacy_mode = q[0].leg;
        old_dst = q[0].old;
      end
      acc = in_valid && (!exp_valid || out_ready);
      if (acc) begin
        ref_op(q[0], d, vi, vx);
        exp_dst = d; exp_inv |= vi; exp_inx |= vx; exp_valid = 1;
        exp_tag = q[0].tag;
        void'(q.pop_front());
      end else if (out_ready) begin
        exp_valid = 0;
      end
      cyc++;
    end else begin
      in_valid = 1'b0;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL R10 watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_reset();
    run = 0;
    @(negedge clk);
    rst_n = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11", "out_valid in reset", 512'(out_valid), 512'(0));
    chk(dst_vec === '0, "R11", "dst_vec in reset", dst_vec, '0);
    chk(flag_invalid === 1'b0, "R11", "flag_invalid in reset", 512'(flag_invalid), 512'(0));
    chk(flag_inexact === 1'b0, "R11", "flag_inexact in reset", 512'(flag_inexact), 512'(0));
    exp_valid = 0; exp_inv = 0; exp_inx = 0; exp_tag = "R11";
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic run_phase();
    run = 1;
    while (q.size() > 0 || exp_valid) @(negedge clk);
    @(negedge clk);
    run = 0;
  endtask

  initial begin
    op_t o;
    // Phase 1: exact values, no flags expected
    do_reset();
    o = mk("R1 R4 two lanes", 0, 8'hFF, 0, 0, 0);
    o.src[63:0] = $realtobits(5.0); o.src[127:64] = $realtobits(-7.0);
    q.push_back(o);
    o = mk("R3 R4 four lanes exact limits", 1, 8'hFF, 0, 0, 0);
    o.src[191:128] = $realtobits(2147483647.0); o.src[255:192] = $realtobits(-2147483648.0);
    q.push_back(o);
    o = mk("R4 eight lanes sel2", 2, 8'hFF, 0, 0, 0);
    for (int i = 0; i < 8; i++) o.src[64*i +: 64] = $realtobits(real'(i * 1000 - 3000));
    q.push_back(o);
    q.push_back(mk("R4 eight lanes sel3", 3, 8'hFF, 1, 0, 0));
    o = mk("R5 broadcast", 2, 8'hFF, 0, 0, 1);
    o.src[63:0] = $realtobits(-123.0);
    for (int i = 1; i < 8; i++) o.src[64*i +: 64] = 64'h7FF8_0000_0000_0001;
    q.push_back(o);
    o = mk("R6 R9 merge masked", 1, 8'b0101, 0, 0, 0);
    o.src[127:64] = 64'h7FF8_0000_0000_0000; o.src[255:192] = $realtobits(0.5);
    q.push_back(o);
    o = mk("R6 R9 zeroing masked", 1, 8'b0101, 1, 0, 0);
    o.src[127:64] = 64'hFFF0_0000_0000_0000;
    q.push_back(o);
    q.push_back(mk("R6 merge mask all off", 2, 8'h00, 0, 0, 0));
    q.push_back(mk("R7 two lanes clear upper", 0, 8'hFF, 0, 0, 0));
    q.push_back(mk("R8 legacy two lanes", 0, 8'h00, 1, 1, 0));
    q.push_back(mk("R8 legacy ignored for four lanes", 1, 8'b0010, 0, 1, 0));
    run_phase();
    chk(flag_invalid === 1'b0 && flag_inexact === 1'b0, "R9",
        "no flags from masked lanes", 512'({flag_invalid, flag_inexact}), '0);

    // Phase 2: inexact only
    do_reset();
    o = mk("R1 R9 truncation", 0, 8'hFF, 0, 0, 0);
    o.src[63:0] = $realtobits(2.7); o.src[127:64] = $realtobits(-2.7);
    q.push_back(o);
    o = mk("R9 subnormal and small", 1, 8'hFF, 0, 0, 0);
    o.src[63:0] = 64'h0000_0000_0000_0001; o.src[127:64] = $realtobits(-0.9);
    o.src[191:128] = $realtobits(2147483647.99);
    q.push_back(o);
    run_phase();
    chk(flag_invalid === 1'b0 && flag_inexact === 1'b1, "R9",
        "inexact without invalid", 512'({flag_invalid, flag_inexact}), 512'(2'b01));

    // Phase 3: invalid inputs
    do_reset();
    o = mk("R2 nan and inf", 1, 8'hFF, 0, 0, 0);
    o.src[63:0] = 64'h7FF8_0000_0000_0000; o.src[127:64] = 64'h7FF0_0000_0000_0000;
    o.src[191:128] = 64'hFFF0_0000_0000_0000;
    q.push_back(o);
    o = mk("R3 range edges", 2, 8'hFF, 0, 0, 0);
    o.src[63:0] = $realtobits(2147483648.0); o.src[127:64] = $realtobits(-2147483649.0);
    o.src[191:128] = $realtobits(-2147483648.75); o.src[255:192] = $realtobits(1.0e300);
    o.src[319:256] = $realtobits(-2147483648.0); o.src[383:320] = $realtobits(-4294967296.0);
    q.push_back(o);
    run_phase();
    chk(flag_invalid === 1'b1, "R2 R3", "invalid raised", 512'(flag_invalid), 512'(1));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule